// File: doc/BRIEF.md
# Short Relative Branch Resolver

This block resolves one short conditional branch. It takes an 8-bit branch opcode, an 8-bit two's-complement displacement, the address of the branch instruction and the four condition flags: negative, zero, overflow and carry. From these it works out whether the branch is taken, which address is fetched next, and how many program-fetch cycles the instruction costs. A sequencer uses the result to steer its fetch unit. A flag marks opcodes that are not in the supported short-branch set.

The opcode map is fixed. It holds signed comparisons (less-than, less-or-equal), unsigned comparisons (lower, lower-or-same), single-flag tests, and the always and never forms. The address step, the displacement width, the cycle costs, and whether the outputs pass through a register stage are all parameters. The default build registers the outputs, so results appear one clock after the inputs are presented.

Top module: `brc_unit`

## Requirements
- R1: When the branch is not taken, out_next_pc equals in_pc + 2, modulo 2^16.
- R2: When the branch is taken, out_next_pc equals in_pc + 2 + the sign-extended in_disp (bit 7 is the sign), modulo 2^16.
- R3: Signed tests. Opcode 0x2D is taken when N XOR V is 1. Opcode 0x2F is taken when Z OR (N XOR V) is 1.
- R4: Unsigned tests. Opcode 0x25 is taken when C is 1. Opcode 0x23 is taken when C OR Z is 1.
- R5: Opcode 0x26 is taken when Z is 0. Opcode 0x2B is taken when N is 1. Opcode 0x2A is taken when N is 0.
- R6: Opcode 0x29 is taken when V is 1. Opcode 0x28 is taken when V is 0.
- R7: Opcode 0x20 is taken for every flag combination. Opcode 0x21 is never taken.
- R8: out_fetch_cycles is 3 when the branch is taken and 1 when it is not. The never form therefore always gives 1.
- R9: Any opcode outside {0x20, 0x21, 0x23, 0x25, 0x26, 0x28, 0x29, 0x2A, 0x2B, 0x2D, 0x2F} gives out_valid 0, out_taken 0, out_next_pc equal to in_pc + 2, and out_fetch_cycles 1.
- R10: The outputs are registered. They show the inputs sampled at the previous rising clk edge. While rst_n is low, every output is 0.
- R11: Every opcode in the supported set gives out_valid 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_op | input | 8 | Branch opcode |
| in_disp | input | 8 | Signed displacement |
| in_pc | input | 16 | Address of the branch instruction |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| out_valid | output | 1 | Opcode is a supported short branch |
| out_taken | output | 1 | Branch condition holds |
| out_next_pc | output | 16 | Next fetch address |
| out_fetch_cycles | output | 2 | Program-fetch cycle count |

## Verification
A wrong condition mapping shows up as a wrong out_taken one clock after the bad flag pattern is applied. Because out_next_pc and out_fetch_cycles follow out_taken, the same error also appears on both of them in that cycle. A stale or misaligned output register shows up as outputs belonging to the previous vector. The sweep of every opcode against every flag combination therefore exposes any decode or evaluation fault at its first affected vector. The displacement sweeps at the two ends of the address space expose sign-extension and wrap faults.

// File: rtl/brc_pkg.sv
package brc_pkg;

   localparam int OPC_W = 8;

   typedef enum logic [3:0] {
      CND_ALWAYS,
      CND_NEVER,
      CND_LOWER_SAME,
      CND_LOWER,
      CND_NOT_ZERO,
      CND_OVF_CLEAR,
      CND_OVF_SET,
      CND_PLUS,
      CND_MINUS,
      CND_SLT,
      CND_SLE,
      CND_NONE
   } cond_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } flags_t;

endpackage

// File: rtl/brc_decode.sv
module brc_decode
   import brc_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   output cond_e            cond,
   output logic             known
);

   always_comb begin
      unique case (opcode)
         8'h20:   cond = CND_ALWAYS;
         8'h21:   cond = CND_NEVER;
         8'h23:   cond = CND_LOWER_SAME;
         8'h25:   cond = CND_LOWER;
         8'h26:   cond = CND_NOT_ZERO;
         8'h28:   cond = CND_OVF_CLEAR;
         8'h29:   cond = CND_OVF_SET;
         8'h2A:   cond = CND_PLUS;
         8'h2B:   cond = CND_MINUS;
         8'h2D:   cond = CND_SLT;
         8'h2F:   cond = CND_SLE;
         default: cond = CND_NONE;
      endcase
      known = (cond != CND_NONE);
   end

endmodule

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
   import brc_pkg::*;
(
   input  cond_e  cond,
   input  flags_t flags,
   output logic   taken
);

   logic sgn_lt;

   always_comb begin
      sgn_lt = flags.n ^ flags.v;
      unique case (cond)
         CND_ALWAYS:     taken = 1'b1;
         CND_NEVER:      taken = 1'b0;
         CND_LOWER_SAME: taken = flags.c | flags.z;
         CND_LOWER:      taken = flags.c;
         CND_NOT_ZERO:   taken = ~flags.z;
         CND_OVF_CLEAR:  taken = ~flags.v;
         CND_OVF_SET:    taken = flags.v;
         CND_PLUS:       taken = ~flags.n;
         CND_MINUS:      taken = flags.n;
         CND_SLT:        taken = sgn_lt;
         CND_SLE:        taken = flags.z | sgn_lt;
         default:        taken = 1'b0;
      endcase
   end

endmodule

// File: rtl/brc_target.sv
module brc_target #(
   parameter int PC_W   = 16,
   parameter int DISP_W = 8,
   parameter int STEP   = 2
) (
   input  logic [PC_W-1:0]   pc,
   input  logic [DISP_W-1:0] disp,
   input  logic              take,
   output logic [PC_W-1:0]   next_pc
);

   localparam int EXT_W = PC_W - DISP_W;

   logic [PC_W-1:0] seq_pc;
   logic [PC_W-1:0] disp_ext;
   logic [PC_W-1:0] jump_pc;

   generate
      if (EXT_W > 0) begin : g_ext
         assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
      end else begin : g_same
         assign disp_ext = disp[PC_W-1:0];
      end
   endgenerate

   always_comb begin
      seq_pc  = pc + PC_W'(STEP);
      jump_pc = seq_pc + disp_ext;
      next_pc = take ? jump_pc : seq_pc;
   end

endmodule

// File: rtl/brc_unit.sv
module brc_unit
   import brc_pkg::*;
#(
   parameter int PC_W      = 16,
   parameter int DISP_W    = 8,
   parameter int STEP      = 2,
   parameter int TAKEN_CYC = 3,
   parameter int SKIP_CYC  = 1,
   parameter bit REG_OUT   = 1'b1,
   localparam int CYC_W    = $clog2(TAKEN_CYC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OPC_W-1:0]  in_op,
   input  logic [DISP_W-1:0] in_disp,
   input  logic [PC_W-1:0]   in_pc,
   input  logic              flag_n,
   input  logic              flag_z,
   input  logic              flag_v,
   input  logic              flag_c,
   output logic              out_valid,
   output logic              out_taken,
   output logic [PC_W-1:0]   out_next_pc,
   output logic [CYC_W-1:0]  out_fetch_cycles
);

   generate
      if (DISP_W > PC_W) begin : g_bad_disp
         $error("brc_unit: DISP_W must not exceed PC_W");
      end
      if (SKIP_CYC > TAKEN_CYC) begin : g_bad_cyc
         $error("brc_unit: SKIP_CYC must not exceed TAKEN_CYC");
      end
      if (STEP < 1) begin : g_bad_step
         $error("brc_unit: STEP must be positive");
      end
   endgenerate

   cond_e            cond;
   logic             known;
   logic             cond_hit;
   logic             take;
   flags_t           flags;
   logic [PC_W-1:0]  nxt_pc;
   logic [CYC_W-1:0] cyc;

   assign flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

   brc_decode u_dec (
      .opcode (in_op),
      .cond   (cond),
      .known  (known)
   );

   brc_cond_eval u_eval (
      .cond  (cond),
      .flags (flags),
      .taken (cond_hit)
   );

   assign take = cond_hit & known;

   brc_target #(
      .PC_W   (PC_W),
      .DISP_W (DISP_W),
      .STEP   (STEP)
   ) u_tgt (
      .pc      (in_pc),
      .disp    (in_disp),
      .take    (take),
      .next_pc (nxt_pc)
   );

   assign cyc = take ? CYC_W'(TAKEN_CYC) : CYC_W'(SKIP_CYC);

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_valid        <= 1'b0;
               out_taken        <= 1'b0;
               out_next_pc      <= '0;
               out_fetch_cycles <= '0;
            end else begin
               out_valid        <= known;
               out_taken        <= take;
               out_next_pc      <= nxt_pc;
               out_fetch_cycles <= cyc;
            end
         end
      end else begin : g_comb
         always_comb begin
            out_valid        = known & rst_n;
            out_taken        = take & rst_n;
            out_next_pc      = rst_n ? nxt_pc : '0;
            out_fetch_cycles = rst_n ? cyc : '0;
         end
      end
   endgenerate

endmodule

// File: rtl/brc_unit_chk.sv
module brc_unit_chk #(
   parameter int PC_W      = 16,
   parameter int DISP_W    = 8,
   parameter int STEP      = 2,
   parameter int TAKEN_CYC = 3,
   parameter int SKIP_CYC  = 1,
   parameter bit REG_OUT   = 1'b1,
   parameter int CYC_W     = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [7:0]        in_op,
   input logic [DISP_W-1:0] in_disp,
   input logic [PC_W-1:0]   in_pc,
   input logic              out_valid,
   input logic              out_taken,
   input logic [PC_W-1:0]   out_next_pc,
   input logic [CYC_W-1:0]  out_fetch_cycles
);

   logic [7:0]        op_q;
   logic [DISP_W-1:0] disp_q;
   logic [PC_W-1:0]   pc_q;
   logic              primed;
   logic [PC_W-1:0]   seq_e;
   logic [PC_W-1:0]   jmp_e;

   generate
      if (REG_OUT) begin : g_lag
         always_ff @(posedge clk) begin
            op_q   <= in_op;
            disp_q <= in_disp;
            pc_q   <= in_pc;
            primed <= rst_n;
         end
      end else begin : g_now
         assign op_q   = in_op;
         assign disp_q = in_disp;
         assign pc_q   = in_pc;
         assign primed = 1'b1;
      end
   endgenerate

   assign seq_e = pc_q + PC_W'(STEP);
   assign jmp_e = seq_e + PC_W'($signed(disp_q));

   a_r1_seq_pc: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && !out_taken) |-> out_next_pc == seq_e);

   a_r2_jump_pc: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && out_taken) |-> out_next_pc == jmp_e);

   a_r7_always: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && op_q == 8'h20) |-> (out_taken && out_valid));

   a_r7_never: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && op_q == 8'h21) |-> (!out_taken && out_valid));

   a_r8_taken_cost: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && out_taken) |-> out_fetch_cycles == CYC_W'(TAKEN_CYC));

   a_r8_skip_cost: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && !out_taken) |-> out_fetch_cycles == CYC_W'(SKIP_CYC));

   a_r9_unknown_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && !out_valid) |-> !out_taken);

endmodule

bind brc_unit brc_unit_chk #(
   .PC_W      (PC_W),
   .DISP_W    (DISP_W),
   .STEP      (STEP),
   .TAKEN_CYC (TAKEN_CYC),
   .SKIP_CYC  (SKIP_CYC),
   .REG_OUT   (REG_OUT),
   .CYC_W     (CYC_W)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .in_op            (in_op),
   .in_disp          (in_disp),
   .in_pc            (in_pc),
   .out_valid        (out_valid),
   .out_taken        (out_taken),
   .out_next_pc      (out_next_pc),
   .out_fetch_cycles (out_fetch_cycles)
);

// File: tb/brc_unit_test.sv
module brc_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  in_op = '0;
   logic [7:0]  in_disp = '0;
   logic [15:0] in_pc = '0;
   logic        flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
   logic        out_valid, out_taken;
   logic [15:0] out_next_pc;
   logic [1:0]  out_fetch_cycles;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   brc_unit uut (
      .clk              (clk),
      .rst_n            (rst_n),
      .in_op            (in_op),
      .in_disp          (in_disp),
      .in_pc            (in_pc),
      .flag_n           (flag_n),
      .flag_z           (flag_z),
      .flag_v           (flag_v),
      .flag_c           (flag_c),
      .out_valid        (out_valid),
      .out_taken        (out_taken),
      .out_next_pc      (out_next_pc),
      .out_fetch_cycles (out_fetch_cycles)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit is_known(input logic [7:0] op);
      return op inside {8'h20, 8'h21, 8'h23, 8'h25, 8'h26, 8'h28,
                        8'h29, 8'h2A, 8'h2B, 8'h2D, 8'h2F};
   endfunction

   function automatic bit exp_taken(input logic [7:0] op, input logic [3:0] f);
      logic n, z, v, c;
      {n, z, v, c} = f;
      case (op)
         8'h20: return 1'b1;
         8'h21: return 1'b0;
         8'h23: return c | z;
         8'h25: return c;
         8'h26: return !z;
         8'h28: return !v;
         8'h29: return v;
         8'h2A: return !n;
         8'h2B: return n;
         8'h2D: return n != v;
         8'h2F: return z | (n != v);
         default: return 1'b0;
      endcase
   endfunction

   function automatic string op_req(input logic [7:0] op);
      case (op)
         8'h2D, 8'h2F:        return "R3";
         8'h25, 8'h23:        return "R4";
         8'h26, 8'h2A, 8'h2B: return "R5";
         8'h28, 8'h29:        return "R6";
         8'h20, 8'h21:        return "R7";
         default:             return "R9";
      endcase
   endfunction

   task automatic apply_and_check(input logic [7:0] op, input logic [3:0] f,
                                  input logic [15:0] pc, input logic [7:0] d);
      bit          tk;
      bit          kn;
      logic [15:0] epc;
      @(negedge clk);
      in_op = op; in_disp = d; in_pc = pc;
      {flag_n, flag_z, flag_v, flag_c} = f;
      kn  = is_known(op);
      tk  = exp_taken(op, f);
      epc = tk ? 16'(pc + 16'd2 + {{8{d[7]}}, d}) : 16'(pc + 16'd2);
      @(negedge clk);
      check(op_req(op), "taken", 32'(out_taken), 32'(tk));
      check(kn ? "R11" : "R9", "valid", 32'(out_valid), 32'(kn));
      check(tk ? "R2" : (kn ? "R1" : "R9"), "next_pc", 32'(out_next_pc), 32'(epc));
      check(kn ? "R8" : "R9", "cycles", 32'(out_fetch_cycles), tk ? 32'd3 : 32'd1);
   endtask

   task automatic report;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      // R10: reset clears outputs
      repeat (3) @(negedge clk);
      in_op = 8'h20; in_pc = 16'h1234; in_disp = 8'h10;
      @(negedge clk);
      check("R10", "reset valid", 32'(out_valid), 32'd0);
      check("R10", "reset taken", 32'(out_taken), 32'd0);
      check("R10", "reset pc", 32'(out_next_pc), 32'd0);
      check("R10", "reset cycles", 32'(out_fetch_cycles), 32'd0);
      rst_n = 1'b1;

      // R10: one-clock latency; output holds until the next edge
      apply_and_check(8'h20, 4'h0, 16'h0100, 8'h04);
      in_op = 8'h21; in_pc = 16'h0200;
      #1;
      check("R10", "hold before edge", 32'(out_next_pc), 32'h0106);
      @(negedge clk);
      check("R10", "after edge", 32'(out_next_pc), 32'h0202);

      // Sweep every opcode against every flag combination
      for (int op = 0; op < 256; op++) begin
         for (int f = 0; f < 16; f++) begin
            apply_and_check(8'(op), 4'(f), 16'(op * 257 ^ f * 4099), 8'(op ^ (f * 17)));
         end
      end

      // R2: displacement sweep across both ends of the address space
      for (int d = 0; d < 256; d++) begin
         apply_and_check(8'h20, 4'h0, 16'hFFF0, 8'(d));
         apply_and_check(8'h20, 4'h0, 16'h0004, 8'(d));
      end

      // R1: sequential wrap, never form and unknown opcode at top of space
      apply_and_check(8'h21, 4'hF, 16'hFFFE, 8'h80);
      apply_and_check(8'h21, 4'hF, 16'hFFFF, 8'h7F);
      apply_and_check(8'h00, 4'hF, 16'hFFFF, 8'h7F);

      done = 1'b1;
      report();
   end

endmodule